// File: doc/BRIEF.md
# Multi-Array Memory Self-Test Address Sequencer

This block generates the address stream for a built-in self-test of four cache arrays: valid, tag, parity and data. A one-cycle start pulse latches a configuration word. The block then issues one address per clock. Each address carries an array-select vector, a row address, a column address and a sweep-direction flag. A one-cycle done pulse follows the last address.

The tag and valid arrays can share a single sweep or be swept one after the other. In the shared sweep, the tag array's settings apply to both. The row address is scrambled by XOR with a per-array key. Each array can also step its two lowest column bits in Gray order instead of binary order. Row counts are checked against the configured cache size, and an illegal setting blocks the start.

Data patterns, read comparison and failure logging belong to the surrounding self-test engine.

Top module: `mbist_addr_seq`

## Requirements
- R1: After reset, addr_valid and done are 0 and array_sel is 4'b0000 until a start is accepted.
- R2: config_error is 1 exactly when a row count is out of range for cache_size (0=128 KB, 1=256 KB, 2=512 KB, 3=1024 KB). The legal ranges are: dp_rows 32..512 (64..512 at code 3); tv_rows 16..128 (16..256 at code 3).
- R3: A start while config_error is 1 is ignored: no address is issued and no done pulse follows.
- R4: Within one array, the column index advances fastest and the row index after each full column pass. Going up (sweep_down=0), rows run 0..N-1 and columns run 0..2^COL_W-1. Going down, both run in reverse. The output down shows the latched direction.
- R5: lsb_gray bit 0 controls the valid array, bit 1 the tag array, bit 2 the parity array and bit 3 the data array. When the controlling bit is 1, col_addr[1:0] takes the values 00,01,11,10 going up and the reverse going down. When the bit is 0, these two bits count in binary.
- R6: With serial_tv=0, the tag and valid arrays share one sweep of tv_rows rows. array_sel is {2'b00, array_en[1:0]}, and the sweep uses key_tag and lsb_gray[1] even when only the valid array is enabled.
- R7: With serial_tv=1, the tag sweep (array_sel 4'b0010, key_tag, lsb_gray[1]) completes before the valid sweep (array_sel 4'b0001, key_valid, lsb_gray[0]) begins.
- R8: The sweep order is tag/valid, then parity (4'b0100), then data (4'b1000). Arrays whose array_en bit (bit 0 valid, 1 tag, 2 parity, 3 data) is 0 are skipped. Parity and data use dp_rows rows.
- R9: row_addr equals the logical row index XOR the scramble key of the current sweep.
- R10: addr_valid is 1 for one cycle per address, starting in the cycle after start is sampled. done is 1 for exactly the one cycle after the last address. With no array enabled, done is 1 in the cycle after start.
- R11: The configuration is latched when a start is accepted. Changes to it, and further start pulses, have no effect while a sweep is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (one-cycle pulse) |
| cache_size | input | 2 | Cache size code: 0=128, 1=256, 2=512, 3=1024 KB |
| dp_rows | input | ROW_W+1 | Row count for the parity and data arrays |
| tv_rows | input | ROW_W+1 | Row count for the tag and valid arrays |
| array_en | input | 4 | Arrays to test: bit 0 valid, 1 tag, 2 parity, 3 data |
| key_valid | input | ROW_W | Row scramble key, valid array |
| key_tag | input | ROW_W | Row scramble key, tag array |
| key_parity | input | ROW_W | Row scramble key, parity array |
| key_data | input | ROW_W | Row scramble key, data array |
| serial_tv | input | 1 | 1 = sweep tag and valid one after the other |
| lsb_gray | input | 4 | Per-array Gray stepping of column bits [1:0] |
| sweep_down | input | 1 | 1 = descending sweep |
| addr_valid | output | 1 | Address outputs are valid this cycle |
| array_sel | output | 4 | Arrays addressed this cycle |
| row_addr | output | ROW_W | Scrambled row address |
| col_addr | output | COL_W | Column address |
| down | output | 1 | Latched sweep direction |
| done | output | 1 | One-cycle pulse after the last address |
| config_error | output | 1 | Row counts illegal for the cache size |

## Verification
The hardest situation to reach is a sweep in which the valid array runs under the tag array's key and Gray setting while the tag array itself is disabled. To reach it, the stimulus enables only the valid array in shared mode and gives the two arrays different keys and Gray bits, so that any borrowing of the valid array's own settings shows up in the addresses. A second hard case is a change to every configuration input, plus a second start pulse, partway through a sweep. The stimulus does this inside a running descending sweep and checks the stream against the addresses predicted from the configuration held at the start. Every clock of every sweep is compared with a behavioural model of the whole address stream.

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
  parameter int ROW_W = 9,
  parameter int COL_W = 4,
  localparam int CNT_W = ROW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cache_size,
  input  logic [CNT_W-1:0] dp_rows,
  input  logic [CNT_W-1:0] tv_rows,
  input  logic [3:0]       array_en,
  input  logic [ROW_W-1:0] key_valid,
  input  logic [ROW_W-1:0] key_tag,
  input  logic [ROW_W-1:0] key_parity,
  input  logic [ROW_W-1:0] key_data,
  input  logic             serial_tv,
  input  logic [3:0]       lsb_gray,
  input  logic             sweep_down,
  output logic             addr_valid,
  output logic [3:0]       array_sel,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic             down,
  output logic             done,
  output logic             config_error
);

  localparam logic [CNT_W-1:0] DP_MIN_S = CNT_W'(32);
  localparam logic [CNT_W-1:0] DP_MIN_L = CNT_W'(64);
  localparam logic [CNT_W-1:0] DP_MAX   = CNT_W'(512);
  localparam logic [CNT_W-1:0] TV_MIN   = CNT_W'(16);
  localparam logic [CNT_W-1:0] TV_MAX_S = CNT_W'(128);
  localparam logic [CNT_W-1:0] TV_MAX_L = CNT_W'(256);

  // phase 0: tag (or shared tag/valid), 1: valid (serial only), 2: parity, 3: data
  function automatic logic [3:0] act_mask(input logic [3:0] en, input logic ser);
    act_mask = {en[3], en[2], ser & en[0], ser ? en[1] : (en[0] | en[1])};
  endfunction

  function automatic logic [2:0] pick(input logic [3:0] m, input logic [2:0] from);
    pick = 3'b000;
    for (int i = 3; i >= 0; i--)
      if (m[i] && 3'(i) >= from) pick = {1'b1, 2'(i)};
  endfunction

  logic             busy, done_q;
  logic [1:0]       phase;
  logic [ROW_W-1:0] ri;
  logic [COL_W-1:0] ci;

  logic [3:0]       c_en, c_lsb;
  logic             c_ser, c_down;
  logic [CNT_W-1:0] c_dp, c_tv;
  logic [ROW_W-1:0] c_kv, c_kt, c_kp, c_kd;

  logic             big, dp_ok, tv_ok;
  logic [2:0]       first_ph, nxt_ph;
  logic [CNT_W-1:0] n_rows;
  logic             last_r, last_c, g_sel;
  logic [ROW_W-1:0] key_sel, r_log;
  logic [COL_W-1:0] c_log;

  assign big   = cache_size == 2'd3;
  assign dp_ok = dp_rows >= (big ? DP_MIN_L : DP_MIN_S) && dp_rows <= DP_MAX;
  assign tv_ok = tv_rows >= TV_MIN && tv_rows <= (big ? TV_MAX_L : TV_MAX_S);
  assign config_error = !(dp_ok && tv_ok);

  assign first_ph = pick(act_mask(array_en, serial_tv), 3'd0);
  assign nxt_ph   = pick(act_mask(c_en, c_ser), {1'b0, phase} + 3'd1);

  assign n_rows = phase[1] ? c_dp : c_tv;
  assign last_r = {1'b0, ri} == n_rows - CNT_W'(1);
  assign last_c = &ci;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      phase  <= 2'd0;
      ri     <= '0;
      ci     <= '0;
      c_en   <= '0;
      c_lsb  <= '0;
      c_ser  <= 1'b0;
      c_down <= 1'b0;
      c_dp   <= '0;
      c_tv   <= '0;
      c_kv   <= '0;
      c_kt   <= '0;
      c_kp   <= '0;
      c_kd   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start && !config_error) begin
          c_en   <= array_en;
          c_lsb  <= lsb_gray;
          c_ser  <= serial_tv;
          c_down <= sweep_down;
          c_dp   <= dp_rows;
          c_tv   <= tv_rows;
          c_kv   <= key_valid;
          c_kt   <= key_tag;
          c_kp   <= key_parity;
          c_kd   <= key_data;
          busy   <= first_ph[2];
          phase  <= first_ph[1:0];
          ri     <= '0;
          ci     <= '0;
          done_q <= !first_ph[2];
        end
      end else begin
        ci <= ci + COL_W'(1);
        if (last_c) begin
          if (!last_r) begin
            ri <= ri + ROW_W'(1);
          end else begin
            ri <= '0;
            if (nxt_ph[2]) phase <= nxt_ph[1:0];
            else begin
              busy   <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (phase)
      2'd0:    begin key_sel = c_kt; g_sel = c_lsb[1]; end
      2'd1:    begin key_sel = c_kv; g_sel = c_lsb[0]; end
      2'd2:    begin key_sel = c_kp; g_sel = c_lsb[2]; end
      default: begin key_sel = c_kd; g_sel = c_lsb[3]; end
    endcase
  end

  always_comb begin
    array_sel = 4'b0000;
    if (busy) begin
      case (phase)
        2'd0:    array_sel = c_ser ? 4'b0010 : {2'b00, c_en[1:0]};
        2'd1:    array_sel = 4'b0001;
        2'd2:    array_sel = 4'b0100;
        default: array_sel = 4'b1000;
      endcase
    end
  end

  assign r_log = c_down ? ROW_W'(n_rows - CNT_W'(1) - {1'b0, ri}) : ri;
  assign c_log = c_down ? ~ci : ci;

  assign row_addr   = r_log ^ key_sel;
  assign col_addr   = {c_log[COL_W-1:2],
                       g_sel ? {c_log[1], c_log[1] ^ c_log[0]} : c_log[1:0]};
  assign down       = c_down;
  assign addr_valid = busy;
  assign done       = done_q;

endmodule

// File: rtl/mbist_addr_seq_chk.sv
module mbist_addr_seq_chk #(
  parameter int ROW_W = 9,
  parameter int COL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             config_error,
  input logic             addr_valid,
  input logic [3:0]       array_sel,
  input logic [ROW_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr,
  input logic             down,
  input logic             done
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  assert_idle_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> array_sel == 4'b0000);

  assert_sel_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ($countones(array_sel) == 1 || array_sel == 4'b0011));

  assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |-> $stable(down));

  assert_row_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && array_sel == $past(array_sel) &&
     row_addr != $past(row_addr))
    |-> col_addr[COL_W-1:2] == (down ? {(COL_W-2){1'b1}} : {(COL_W-2){1'b0}}));

  assert_bad_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && config_error && !addr_valid) |=> (!addr_valid && !done));

endmodule

bind mbist_addr_seq mbist_addr_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .config_error(config_error),
  .addr_valid(addr_valid), .array_sel(array_sel), .row_addr(row_addr),
  .col_addr(col_addr), .down(down), .done(done)
);

// File: tb/sim_mbist_addr_seq.sv
`timescale 1ns/100ps
module sim_mbist_addr_seq;
  localparam int ROW_W = 9;
  localparam int COL_W = 4;
  localparam int NCOL  = 1 << COL_W;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cs = 0;
  logic [ROW_W:0] rdp = 32, rtv = 16;
  logic [3:0] en = 4'hF, lsb = 0;
  logic ser = 0, dn = 0;
  logic [ROW_W-1:0] kv = 0, kt = 0, kp = 0, kd = 0;

  logic addr_valid, down, done, config_error;
  logic [3:0] array_sel;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;

  int checks = 0, errors = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  mbist_addr_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cache_size(cs),
    .dp_rows(rdp), .tv_rows(rtv), .array_en(en),
    .key_valid(kv), .key_tag(kt), .key_parity(kp), .key_data(kd),
    .serial_tv(ser), .lsb_gray(lsb), .sweep_down(dn),
    .addr_valid(addr_valid), .array_sel(array_sel), .row_addr(row_addr),
    .col_addr(col_addr), .down(down), .done(done), .config_error(config_error)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int observed();
    return int'({addr_valid, array_sel, down, row_addr, col_addr});
  endfunction

  function automatic int lsb_map(input int v, input bit g);
    if (!g) return v;
    case (v)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic build();
    exp_q.delete();
    for (int p = 0; p < 4; p++) begin
      bit act, g;
      int sel, key, n;
      case (p)
        0: begin
          act = ser ? en[1] : (en[0] | en[1]);
          sel = ser ? 2 : int'(en[1:0]);
          key = kt; g = lsb[1]; n = rtv;
        end
        1: begin act = ser & en[0]; sel = 1; key = kv; g = lsb[0]; n = rtv; end
        2: begin act = en[2]; sel = 4; key = kp; g = lsb[2]; n = rdp; end
        default: begin act = en[3]; sel = 8; key = kd; g = lsb[3]; n = rdp; end
      endcase
      if (act)
        for (int r = 0; r < n; r++)
          for (int c = 0; c < NCOL; c++) begin
            int rl, cl, col, row;
            rl  = dn ? n - 1 - r : r;
            cl  = dn ? NCOL - 1 - c : c;
            col = (cl / 4) * 4 + lsb_map(cl % 4, g);
            row = rl ^ key;
            exp_q.push_back((1 << 18) | (sel << 14) | (int'(dn) << 13) | (row << 4) | col);
          end
    end
  endtask

  task automatic run(input string req, input bit perturb);
    int n;
    build();
    n = exp_q.size();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk(req, observed(), exp_q[i]);
      if (perturb && i == 20) begin
        start = 1; kt = ~kt; kv = ~kv; kp = ~kp; kd = ~kd;
        lsb = ~lsb; dn = ~dn; ser = ~ser; en = ~en; rtv = 999;
      end
      if (perturb && i == 21) start = 0;
    end
    if (n > 0) @(negedge clk);
    chk({req, " done pulse R10"}, int'({addr_valid, done}), 1);
    @(negedge clk);
    chk({req, " done ends R10"}, int'({addr_valid, done}), 0);
  endtask

  task automatic cfg_chk(input int c, input int d, input int t, input bit e);
    @(negedge clk);
    cs = 2'(c); rdp = 10'(d); rtv = 10'(t);
    #1 chk($sformatf("R2 size %0d dp %0d tv %0d", c, d, t), int'(config_error), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'({addr_valid, done, array_sel}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", int'({addr_valid, done, array_sel}), 0);

    cfg_chk(0, 16, 16, 1);
    cfg_chk(0, 32, 16, 0);
    cfg_chk(1, 512, 128, 0);
    cfg_chk(2, 513, 128, 1);
    cfg_chk(2, 32, 15, 1);
    cfg_chk(0, 32, 256, 1);
    cfg_chk(3, 32, 16, 1);
    cfg_chk(3, 64, 256, 0);
    cfg_chk(3, 64, 257, 1);

    cs = 0; rdp = 16; rtv = 16;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R3 illegal start ignored", int'({addr_valid, done}), 0);
      @(negedge clk);
    end

    cs = 0; rdp = 32; rtv = 16; en = 4'hF; ser = 0; lsb = 0; dn = 0;
    kv = 9'h0AA; kt = 9'h015; kp = 9'h1F0; kd = 9'h003;
    run("R4 R6 R8 R9 parallel up", 0);

    ser = 1; dn = 1; lsb = 4'b0101;
    run("R4 R5 R7 R9 serial down", 0);

    ser = 0; dn = 0; en = 4'b0001; lsb = 4'b0010; kv = 9'h1FF; kt = 9'h055;
    run("R6 valid only uses tag settings", 0);

    cs = 3; rdp = 64; rtv = 256; en = 4'b1000; lsb = 4'b1000; dn = 1;
    run("R5 R8 data only large", 0);

    cs = 0; rdp = 32; rtv = 16; en = 4'b1010; ser = 1; lsb = 4'b0100; dn = 0;
    run("R8 tag and data skip", 0);

    en = 4'b0000;
    run("R10 empty selection", 0);

    en = 4'b0111; ser = 0; dn = 1; lsb = 4'b0011;
    kv = 9'h101; kt = 9'h0F0; kp = 9'h033; kd = 9'h1C7;
    run("R11 config held during sweep", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule